// File: doc/BRIEF.md
# Special Function Register Bank

This block holds the core registers of a small 8-bit controller: the accumulator, a second operand register, the program status word, the stack pointer, a 16-bit data pointer, four I/O port latches and a serial data buffer. They sit in the byte address window 80H to FFH. Software reaches them through a single-cycle read/write bus. Registers whose address is a multiple of eight can also be reached one bit at a time through a separate bit port.

Hardware next to the bank uses side ports. Push and pop strobes step the stack pointer. A 16-bit load and increment port drives the data pointer. The serial buffer is split: a bus write fills a transmit register and pulses a start strobe, and a receive load input fills a separate receive register that bus reads return. Two values are continuous outputs. The first is the even-parity bit of the accumulator. The second is the base address of the working register bank selected by the status word.

Reads are combinational from the current register state. Every write, whether from the bus, the bit port or hardware, takes effect at the next rising clock edge.

Top module: `sfr_bank`

## Requirements
- R1: After reset, the four port latches read FFH and the stack pointer reads 07H. The accumulator, B, status word, data pointer and both serial registers read 00H, `tx_start` is low and `bank_base` is 00H. `port_latch[7:0]` carries the port at 80H, `[15:8]` the one at 90H, `[23:16]` A0H and `[31:24]` B0H.
- R2: A push strobe alone increments the stack pointer before use, so `stack_ptr` after the push is the slot written. From 07H the first push gives 08H, and FFH wraps to 00H.
- R3: A pop strobe alone decrements the stack pointer after use. `stack_ptr` before the pop is the slot read, and 00H wraps to FFH. Push and pop in the same cycle leave it unchanged.
- R4: A bus write to the stack pointer (81H) in the same cycle as a push or pop wins over them.
- R5: The data pointer reads as a 16-bit `dptr` and as bytes at 82H (low) and 83H (high). `dp_load` takes priority over `dp_inc`, and the increment wraps FFFFH to 0000H. A bus write to one byte overrides the hardware update of that byte only.
- R6: A bus write to 99H stores the byte on `tx_data`, and `tx_start` is high for exactly the following cycle. `rx_load` stores `rx_data`, and a bus read of 99H returns that receive byte, not the transmit byte.
- R7: In the status word at D0H, bit 0 always reads as the XOR of all accumulator (E0H) bits, whatever was written to it. `acc_parity` carries the same value.
- R8: Status word bits 4:3 select the working bank. `bank_base` is 00H, 08H, 10H or 18H for the values 0 to 3.
- R9: The bit address has bit 7 set. Bits [7:3] name the register at the byte address {bits[7:3],000}, and bits [2:0] name the bit. `bit_we` writes `bit_wval` to that bit and leaves the other seven unchanged. `bit_rdata` returns that bit.
- R10: A bus write and a bit write to the same register in one cycle leave the bus byte. When they target different registers, both take effect.
- R11: Addresses other than 80H, 81H, 82H, 83H, 90H, 99H, A0H, B0H, D0H, E0H and F0H ignore writes and read as `UNDEF_VAL`. Bit reads of an aligned base with no register return the matching bit of `UNDEF_VAL`. A bit address with bit 7 clear reads 0 and its writes are ignored.
- R12: A bus read returns the register at `bus_addr` in the same cycle, combinationally. A value written at one edge is read back right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address for bus read and write |
| bus_wr | input | 1 | Bus write enable |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational) |
| bit_addr | input | 8 | Bit address for bit read and write |
| bit_we | input | 1 | Bit write enable |
| bit_wval | input | 1 | Value written to the addressed bit |
| bit_rdata | output | 1 | Value of the addressed bit |
| sp_push | input | 1 | Push strobe: pre-increment stack pointer |
| sp_pop | input | 1 | Pop strobe: post-decrement stack pointer |
| stack_ptr | output | 8 | Current stack pointer |
| dp_load | input | 1 | Load data pointer from `dp_load_val` |
| dp_load_val | input | 16 | Data pointer load value |
| dp_inc | input | 1 | Increment data pointer |
| dptr | output | 16 | Current data pointer |
| port_latch | output | 32 | Four port latches, 80H port in the low byte |
| acc_parity | output | 1 | XOR of accumulator bits |
| bank_base | output | 8 | Working register bank base address |
| tx_start | output | 1 | One-cycle pulse after a write to the serial buffer |
| tx_data | output | 8 | Transmit byte |
| rx_load | input | 1 | Store `rx_data` into the receive register |
| rx_data | input | 8 | Received byte |

## Verification
The main read/write path is swept over the whole 80H–FFH window with an address-dependent pattern. This separates the eleven decoded registers from the holes and shows any aliasing between them. The parity flag is tried with all 256 accumulator values, so a wrong XOR tree or a stored parity bit shows up. Bit set and clear go over every bit of every bit-addressable register, which catches wrong bit or base selection and damage to neighbouring bits. The stack pointer is pushed around its full range to catch wrap errors. The data pointer is crossed at FFFFH and at a carry into the high byte while a bus byte write lands in the same cycle. Same-cycle collisions between bus and bit writes, and between the bus and push, show the stated priorities.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int BYTE_W = 8;
    localparam int RID_W  = 4;
    localparam int NREG   = 1 << RID_W;
    localparam int NPORT  = 4;

    typedef enum logic [RID_W-1:0] {
        RID_NONE,
        RID_P0,
        RID_SP,
        RID_DPL,
        RID_DPH,
        RID_P1,
        RID_SBUF,
        RID_P2,
        RID_P3,
        RID_PSW,
        RID_ACC,
        RID_B
    } reg_id_e;

    localparam logic [BYTE_W-1:0] ADR_P0   = 8'h80;
    localparam logic [BYTE_W-1:0] ADR_SP   = 8'h81;
    localparam logic [BYTE_W-1:0] ADR_DPL  = 8'h82;
    localparam logic [BYTE_W-1:0] ADR_DPH  = 8'h83;
    localparam logic [BYTE_W-1:0] ADR_P1   = 8'h90;
    localparam logic [BYTE_W-1:0] ADR_SBUF = 8'h99;
    localparam logic [BYTE_W-1:0] ADR_P2   = 8'hA0;
    localparam logic [BYTE_W-1:0] ADR_P3   = 8'hB0;
    localparam logic [BYTE_W-1:0] ADR_PSW  = 8'hD0;
    localparam logic [BYTE_W-1:0] ADR_ACC  = 8'hE0;
    localparam logic [BYTE_W-1:0] ADR_B    = 8'hF0;

    localparam reg_id_e PORT_RID [NPORT] = '{RID_P0, RID_P1, RID_P2, RID_P3};

    // status word: bank select sits at bits 4:3, parity at bit 0
    localparam int PSW_BANK_LO = 3;
    localparam int PSW_BANK_W  = 2;
    localparam int BANK_SHIFT  = 3;

endpackage

// File: rtl/sfr_addr_decode.sv
module sfr_addr_decode
    import sfr_pkg::*;
(
    input  logic [BYTE_W-1:0] addr,
    output reg_id_e           rid
);

    always_comb begin
        unique case (addr)
            ADR_P0:   rid = RID_P0;
            ADR_SP:   rid = RID_SP;
            ADR_DPL:  rid = RID_DPL;
            ADR_DPH:  rid = RID_DPH;
            ADR_P1:   rid = RID_P1;
            ADR_SBUF: rid = RID_SBUF;
            ADR_P2:   rid = RID_P2;
            ADR_P3:   rid = RID_P3;
            ADR_PSW:  rid = RID_PSW;
            ADR_ACC:  rid = RID_ACC;
            ADR_B:    rid = RID_B;
            default:  rid = RID_NONE;
        endcase
    end

endmodule

// File: rtl/sfr_byte_reg.sv
module sfr_byte_reg #(
    parameter int           W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= d;
    end

endmodule

// File: rtl/sfr_stack_ptr.sv
module sfr_stack_ptr #(
    parameter int           W   = 8,
    parameter logic [W-1:0] RST = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_we,
    input  logic [W-1:0] sw_data,
    input  logic         push,
    input  logic         pop,
    output logic [W-1:0] sp
);

    always_ff @(posedge clk) begin
        if (!rst_n)             sp <= RST;
        else if (sw_we)         sp <= sw_data;
        else if (push && !pop)  sp <= sp + W'(1);
        else if (pop && !push)  sp <= sp - W'(1);
    end

    assert_push_preinc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !sw_we) |=> sp == $past(sp) + W'(1));

    assert_pop_postdec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !sw_we) |=> sp == $past(sp) - W'(1));

    assert_bus_beats_stack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> sp == $past(sw_data));

endmodule

// File: rtl/sfr_dptr.sv
module sfr_dptr #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lo_we,
    input  logic           hi_we,
    input  logic [W/2-1:0] wdata,
    input  logic           load,
    input  logic [W-1:0]   load_val,
    input  logic           inc,
    output logic [W-1:0]   dptr
);

    localparam int HALF = W / 2;

    logic [W-1:0] hw_next;

    always_comb begin
        if (load)     hw_next = load_val;
        else if (inc) hw_next = dptr + W'(1);
        else          hw_next = dptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dptr <= '0;
        end else begin
            dptr[HALF-1:0] <= lo_we ? wdata : hw_next[HALF-1:0];
            dptr[W-1:HALF] <= hi_we ? wdata : hw_next[W-1:HALF];
        end
    end

    assert_load_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !lo_we && !hi_we) |=> dptr == $past(load_val));

    assert_inc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && !lo_we && !hi_we) |=> dptr == $past(dptr) + W'(1));

    assert_low_byte_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> dptr[HALF-1:0] == $past(wdata));

endmodule

// File: rtl/sfr_bank.sv
module sfr_bank
    import sfr_pkg::*;
#(
    parameter logic [7:0] UNDEF_VAL  = 8'hA5,
    parameter logic [7:0] SP_RESET   = 8'h07,
    parameter logic [7:0] PORT_RESET = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  bit_addr,
    input  logic        bit_we,
    input  logic        bit_wval,
    output logic        bit_rdata,
    input  logic        sp_push,
    input  logic        sp_pop,
    output logic [7:0]  stack_ptr,
    input  logic        dp_load,
    input  logic [15:0] dp_load_val,
    input  logic        dp_inc,
    output logic [15:0] dptr,
    output logic [31:0] port_latch,
    output logic        acc_parity,
    output logic [7:0]  bank_base,
    output logic        tx_start,
    output logic [7:0]  tx_data,
    input  logic        rx_load,
    input  logic [7:0]  rx_data
);

    localparam int BIT_IDX_W = $clog2(BYTE_W);
    localparam int DP_W      = 2 * BYTE_W;

    // write lane: bus wins, the bit port is used otherwise
    function automatic logic [BYTE_W:0] lane(
        input reg_id_e           want,
        input reg_id_e           brid,
        input logic              bwr,
        input logic [BYTE_W-1:0] bdat,
        input reg_id_e           trid,
        input logic              twe,
        input logic [BYTE_W-1:0] tdat
    );
        if (bwr && brid == want) return {1'b1, bdat};
        if (twe && trid == want) return {1'b1, tdat};
        return {1'b0, bdat};
    endfunction

    reg_id_e             bus_rid;
    reg_id_e             bit_rid;
    logic                bit_in_sfr;
    logic                bit_en;
    logic [BYTE_W-1:0]   bit_base;
    logic [BYTE_W-1:0]   bit_byte;
    logic [BYTE_W-1:0]   bit_new;
    logic [BYTE_W-1:0]   view [NREG];

    logic [BYTE_W-1:0]   port_q [NPORT];
    logic [BYTE_W-2:0]   psw_hi;
    logic [BYTE_W-1:0]   acc_q;
    logic [BYTE_W-1:0]   b_q;
    logic [BYTE_W-1:0]   rx_q;

    logic                sp_we,  dpl_we, dph_we, sbuf_we, psw_we, acc_we, b_we;
    logic [BYTE_W-1:0]   sp_d,   dpl_d,  dph_d,  sbuf_d,  psw_d,  acc_d,  b_d;

    assign bit_in_sfr = bit_addr[BYTE_W-1];
    assign bit_en     = bit_we && bit_in_sfr;
    assign bit_base   = {bit_addr[BYTE_W-1:BIT_IDX_W], {BIT_IDX_W{1'b0}}};

    sfr_addr_decode u_dec_bus (.addr(bus_addr), .rid(bus_rid));
    sfr_addr_decode u_dec_bit (.addr(bit_base), .rid(bit_rid));

    // ---------------- read view ----------------
    always_comb begin
        for (int i = 0; i < NREG; i++) view[i] = UNDEF_VAL;
        for (int i = 0; i < NPORT; i++) view[PORT_RID[i]] = port_q[i];
        view[RID_SP]   = stack_ptr;
        view[RID_DPL]  = dptr[BYTE_W-1:0];
        view[RID_DPH]  = dptr[DP_W-1:BYTE_W];
        view[RID_SBUF] = rx_q;
        view[RID_PSW]  = {psw_hi, acc_parity};
        view[RID_ACC]  = acc_q;
        view[RID_B]    = b_q;
    end

    assign bus_rdata = view[bus_rid];
    assign bit_byte  = view[bit_rid];
    assign bit_rdata = bit_in_sfr ? bit_byte[bit_addr[BIT_IDX_W-1:0]] : 1'b0;

    always_comb begin
        bit_new = bit_byte;
        bit_new[bit_addr[BIT_IDX_W-1:0]] = bit_wval;
    end

    // ---------------- write lanes ----------------
    assign {sp_we,   sp_d}   = lane(RID_SP,   bus_rid, bus_wr, bus_wdata, bit_rid, bit_en, bit_new);
    assign {dpl_we,  dpl_d}  = lane(RID_DPL,  bus_rid, bus_wr, bus_wdata, bit_rid, bit_en, bit_new);
    assign {dph_we,  dph_d}  = lane(RID_DPH,  bus_rid, bus_wr, bus_wdata, bit_rid, bit_en, bit_new);
    assign {sbuf_we, sbuf_d} = lane(RID_SBUF, bus_rid, bus_wr, bus_wdata, bit_rid, bit_en, bit_new);
    assign {psw_we,  psw_d}  = lane(RID_PSW,  bus_rid, bus_wr, bus_wdata, bit_rid, bit_en, bit_new);
    assign {acc_we,  acc_d}  = lane(RID_ACC,  bus_rid, bus_wr, bus_wdata, bit_rid, bit_en, bit_new);
    assign {b_we,    b_d}    = lane(RID_B,    bus_rid, bus_wr, bus_wdata, bit_rid, bit_en, bit_new);

    // ---------------- storage ----------------
    for (genvar i = 0; i < NPORT; i++) begin : g_port
        logic              pw_we;
        logic [BYTE_W-1:0] pw_d;
        assign {pw_we, pw_d} = lane(PORT_RID[i], bus_rid, bus_wr, bus_wdata, bit_rid, bit_en, bit_new);

        sfr_byte_reg #(.W(BYTE_W), .RST(PORT_RESET)) u_port (
            .clk(clk), .rst_n(rst_n), .we(pw_we), .d(pw_d), .q(port_q[i])
        );
        assign port_latch[i*BYTE_W +: BYTE_W] = port_q[i];
    end

    // parity bit is not stored: it is rebuilt from the accumulator
    sfr_byte_reg #(.W(BYTE_W-1), .RST('0)) u_psw (
        .clk(clk), .rst_n(rst_n), .we(psw_we), .d(psw_d[BYTE_W-1:1]), .q(psw_hi)
    );
    sfr_byte_reg #(.W(BYTE_W), .RST('0)) u_acc (
        .clk(clk), .rst_n(rst_n), .we(acc_we), .d(acc_d), .q(acc_q)
    );
    sfr_byte_reg #(.W(BYTE_W), .RST('0)) u_b (
        .clk(clk), .rst_n(rst_n), .we(b_we), .d(b_d), .q(b_q)
    );
    sfr_byte_reg #(.W(BYTE_W), .RST('0)) u_tx (
        .clk(clk), .rst_n(rst_n), .we(sbuf_we), .d(sbuf_d), .q(tx_data)
    );
    sfr_byte_reg #(.W(BYTE_W), .RST('0)) u_rx (
        .clk(clk), .rst_n(rst_n), .we(rx_load), .d(rx_data), .q(rx_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) tx_start <= 1'b0;
        else        tx_start <= sbuf_we;
    end

    sfr_stack_ptr #(.W(BYTE_W), .RST(SP_RESET)) u_sp (
        .clk(clk), .rst_n(rst_n), .sw_we(sp_we), .sw_data(sp_d),
        .push(sp_push), .pop(sp_pop), .sp(stack_ptr)
    );

    sfr_dptr #(.W(DP_W)) u_dptr (
        .clk(clk), .rst_n(rst_n), .lo_we(dpl_we), .hi_we(dph_we), .wdata(bus_wdata),
        .load(dp_load), .load_val(dp_load_val), .inc(dp_inc), .dptr(dptr)
    );

    assign acc_parity = ^acc_q;
    assign bank_base  = BYTE_W'({psw_hi[PSW_BANK_LO-1 +: PSW_BANK_W], {BANK_SHIFT{1'b0}}});

    // ---------------- assertions ----------------
    assert_tx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rid == RID_SBUF) |=> (tx_start && tx_data == $past(bus_wdata)));

    assert_tx_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rid == RID_SBUF) |=> !tx_start);

    assert_parity_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rid == RID_ACC) |=> acc_parity == ^$past(bus_wdata));

    assert_bank_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rid == RID_PSW) |=> bank_base[4:3] == $past(bus_wdata[4:3]));

    assert_bus_over_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rid == RID_ACC && bit_en && bit_rid == RID_ACC) |=> acc_q == $past(bus_wdata));

    assert_hole_reads_undef_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rid == RID_NONE) |-> bus_rdata == UNDEF_VAL);

endmodule

// File: tb/test_sfr_bank.sv
module test_sfr_bank;

    localparam logic [7:0] UNDEF = 8'hA5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [7:0]  bus_addr, bus_wdata, bus_rdata;
    logic        bus_wr;
    logic [7:0]  bit_addr;
    logic        bit_we, bit_wval, bit_rdata;
    logic        sp_push, sp_pop;
    logic [7:0]  stack_ptr;
    logic        dp_load, dp_inc;
    logic [15:0] dp_load_val, dptr;
    logic [31:0] port_latch;
    logic        acc_parity;
    logic [7:0]  bank_base;
    logic        tx_start;
    logic [7:0]  tx_data;
    logic        rx_load;
    logic [7:0]  rx_data;

    sfr_bank #(.UNDEF_VAL(UNDEF)) i_sfr_bank (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bit_addr(bit_addr), .bit_we(bit_we), .bit_wval(bit_wval), .bit_rdata(bit_rdata),
        .sp_push(sp_push), .sp_pop(sp_pop), .stack_ptr(stack_ptr),
        .dp_load(dp_load), .dp_load_val(dp_load_val), .dp_inc(dp_inc), .dptr(dptr),
        .port_latch(port_latch), .acc_parity(acc_parity), .bank_base(bank_base),
        .tx_start(tx_start), .tx_data(tx_data), .rx_load(rx_load), .rx_data(rx_data)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [7:0] m [0:255];
    logic [7:0] rx_m;

    function automatic bit implemented(input logic [7:0] a);
        case (a)
            8'h80, 8'h81, 8'h82, 8'h83, 8'h90, 8'h99,
            8'hA0, 8'hB0, 8'hD0, 8'hE0, 8'hF0: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h99) return rx_m;
        if (a == 8'hD0) return {m[8'hD0][7:1], ^m[8'hE0]};
        if (implemented(a)) return m[a];
        return UNDEF;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (implemented(a) && a != 8'h99) m[a] = d;
    endtask

    task automatic rdc(input logic [7:0] a, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp_rd(a), tag, bus_rdata, exp_rd(a));
    endtask

    task automatic bitw(input logic [7:0] ba, input logic v);
        @(negedge clk);
        bit_addr = ba; bit_wval = v; bit_we = 1'b1;
        @(negedge clk);
        bit_we = 1'b0;
        if (ba[7] && implemented({ba[7:3], 3'b000})) m[{ba[7:3], 3'b000}][ba[2:0]] = v;
    endtask

    task automatic strobe_sp(input logic pu, input logic po);
        @(negedge clk);
        sp_push = pu; sp_pop = po;
        @(negedge clk);
        sp_push = 1'b0; sp_pop = 1'b0;
        #1;
    endtask

    task automatic dp_op(input logic ld, input logic [15:0] v, input logic in);
        @(negedge clk);
        dp_load = ld; dp_load_val = v; dp_inc = in;
        @(negedge clk);
        dp_load = 1'b0; dp_inc = 1'b0;
        #1;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] bases [7];
        bases = '{8'h80, 8'h90, 8'hA0, 8'hB0, 8'hD0, 8'hE0, 8'hF0};
        rst_n = 1'b0; bus_addr = 8'h00; bus_wr = 1'b0; bus_wdata = 8'h00;
        bit_addr = 8'h00; bit_we = 1'b0; bit_wval = 1'b0;
        sp_push = 1'b0; sp_pop = 1'b0;
        dp_load = 1'b0; dp_load_val = 16'h0000; dp_inc = 1'b0;
        rx_load = 1'b0; rx_data = 8'h00;
        for (int i = 0; i < 256; i++) m[i] = 8'h00;
        m[8'h80] = 8'hFF; m[8'h90] = 8'hFF; m[8'hA0] = 8'hFF; m[8'hB0] = 8'hFF;
        m[8'h81] = 8'h07;
        rx_m = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 8'h80; a < 256; a++) if (implemented(8'(a))) rdc(8'(a), "R1 reset read");
        chk(stack_ptr == 8'h07, "R1 stack reset", stack_ptr, 8'h07);
        chk(dptr == 16'h0000, "R1 dptr reset", dptr, 0);
        chk(port_latch == 32'hFFFF_FFFF, "R1 ports reset", port_latch, 32'hFFFF_FFFF);
        chk(tx_start == 1'b0 && tx_data == 8'h00, "R1 tx reset", tx_data, 0);
        chk(bank_base == 8'h00 && acc_parity == 1'b0, "R1 bank/parity reset", bank_base, 0);

        // R11 / R12 full window sweep
        for (int a = 8'h80; a < 256; a++) begin
            wr(8'(a), 8'(a) ^ 8'h5C);
            rdc(8'(a), implemented(8'(a)) ? "R12 write then read" : "R11 hole after write");
        end
        for (int a = 8'h80; a < 256; a++)
            rdc(8'(a), implemented(8'(a)) ? "R12 sweep readback" : "R11 hole readback");
        chk(port_latch == {m[8'hB0], m[8'hA0], m[8'h90], m[8'h80]}, "R1 port packing",
            port_latch, {m[8'hB0], m[8'hA0], m[8'h90], m[8'h80]});
        chk(bank_base == 8'h08, "R8 bank after sweep", bank_base, 8'h08);

        // R7 parity over all accumulator values
        for (int v = 0; v < 256; v++) begin
            wr(8'hE0, 8'(v));
            #1;
            chk(acc_parity == ^(8'(v)), "R7 parity output", acc_parity, ^(8'(v)));
            rdc(8'hD0, "R7 status parity bit");
        end
        wr(8'hD0, 8'h01);
        rdc(8'hD0, "R7 parity write overridden");

        // R8 bank base
        for (int k = 0; k < 4; k++) begin
            wr(8'hD0, 8'h80 | 8'(k << 3));
            #1;
            chk(bank_base == 8'(k * 8), "R8 bank base", bank_base, k * 8);
        end

        // R6 split serial buffer
        @(negedge clk);
        bus_addr = 8'h99; bus_wdata = 8'h3C; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk(tx_start == 1'b1 && tx_data == 8'h3C, "R6 tx start pulse", tx_data, 8'h3C);
        @(negedge clk);
        #1;
        chk(tx_start == 1'b0, "R6 tx pulse one cycle", tx_start, 0);
        @(negedge clk);
        rx_load = 1'b1; rx_data = 8'hC3;
        @(negedge clk);
        rx_load = 1'b0;
        rx_m = 8'hC3;
        rdc(8'h99, "R6 read returns receive byte");
        chk(tx_data == 8'h3C, "R6 tx held after receive", tx_data, 8'h3C);

        // R2 / R3 stack
        wr(8'h81, 8'h07);
        strobe_sp(1'b1, 1'b0);
        chk(stack_ptr == 8'h08, "R2 first push at 08", stack_ptr, 8'h08);
        for (int k = 2; k <= 249; k++) begin
            strobe_sp(1'b1, 1'b0);
            chk(stack_ptr == 8'(7 + k), "R2 push climb", stack_ptr, 8'(7 + k));
        end
        chk(stack_ptr == 8'h00, "R2 push wraps to 00", stack_ptr, 0);
        strobe_sp(1'b0, 1'b1);
        chk(stack_ptr == 8'hFF, "R3 pop wraps to FF", stack_ptr, 8'hFF);
        strobe_sp(1'b0, 1'b1);
        chk(stack_ptr == 8'hFE, "R3 pop decrements", stack_ptr, 8'hFE);
        strobe_sp(1'b1, 1'b1);
        chk(stack_ptr == 8'hFE, "R3 push and pop hold", stack_ptr, 8'hFE);

        // R4 bus write beats push/pop
        @(negedge clk);
        sp_push = 1'b1; bus_addr = 8'h81; bus_wdata = 8'h40; bus_wr = 1'b1;
        @(negedge clk);
        sp_push = 1'b0; bus_wr = 1'b0;
        #1;
        chk(stack_ptr == 8'h40, "R4 write beats push", stack_ptr, 8'h40);
        @(negedge clk);
        sp_pop = 1'b1; bus_wdata = 8'h22; bus_wr = 1'b1;
        @(negedge clk);
        sp_pop = 1'b0; bus_wr = 1'b0;
        #1;
        chk(stack_ptr == 8'h22, "R4 write beats pop", stack_ptr, 8'h22);
        m[8'h81] = 8'h22;

        // R5 data pointer
        dp_op(1'b1, 16'hFFFE, 1'b0);
        chk(dptr == 16'hFFFE, "R5 load", dptr, 16'hFFFE);
        m[8'h82] = 8'hFE; m[8'h83] = 8'hFF;
        rdc(8'h82, "R5 low byte view");
        rdc(8'h83, "R5 high byte view");
        dp_op(1'b0, 16'h0000, 1'b1);
        chk(dptr == 16'hFFFF, "R5 inc", dptr, 16'hFFFF);
        dp_op(1'b0, 16'h0000, 1'b1);
        chk(dptr == 16'h0000, "R5 inc wraps", dptr, 0);
        dp_op(1'b1, 16'h1234, 1'b1);
        chk(dptr == 16'h1234, "R5 load beats inc", dptr, 16'h1234);
        dp_op(1'b1, 16'h00FF, 1'b0);
        @(negedge clk);
        dp_inc = 1'b1; bus_addr = 8'h82; bus_wdata = 8'h12; bus_wr = 1'b1;
        @(negedge clk);
        dp_inc = 1'b0; bus_wr = 1'b0;
        #1;
        chk(dptr == 16'h0112, "R5 low byte write with carry", dptr, 16'h0112);
        dp_op(1'b1, 16'h00FF, 1'b0);
        @(negedge clk);
        dp_inc = 1'b1; bus_addr = 8'h83; bus_wdata = 8'h77; bus_wr = 1'b1;
        @(negedge clk);
        dp_inc = 1'b0; bus_wr = 1'b0;
        #1;
        chk(dptr == 16'h7700, "R5 high byte write with inc", dptr, 16'h7700);
        wr(8'h82, 8'hAB);
        chk(dptr == 16'h77AB, "R5 bus byte write", dptr, 16'h77AB);
        m[8'h83] = 8'h77;

        // R9 bit sweep
        for (int b = 0; b < 7; b++) begin
            for (int n = 0; n < 8; n++) begin
                bitw(bases[b] + 8'(n), 1'b1);
                #1;
                chk(bit_rdata == exp_rd(bases[b])[n], "R9 bit set read", bit_rdata, exp_rd(bases[b])[n]);
                rdc(bases[b], "R9 byte after bit set");
                bitw(bases[b] + 8'(n), 1'b0);
                #1;
                chk(bit_rdata == exp_rd(bases[b])[n], "R9 bit clear read", bit_rdata, exp_rd(bases[b])[n]);
                rdc(bases[b], "R9 byte after bit clear");
            end
        end

        // R11 bit holes
        bitw(8'h9B, 1'b0);
        #1;
        chk(bit_rdata == UNDEF[3], "R11 bit hole reads undef", bit_rdata, UNDEF[3]);
        wr(8'hE0, 8'h00);
        bitw(8'h65, 1'b1);
        #1;
        chk(bit_rdata == 1'b0, "R11 low bit address reads 0", bit_rdata, 0);
        rdc(8'hE0, "R11 low bit address write ignored");

        // R10 collisions
        @(negedge clk);
        bus_addr = 8'hE0; bus_wdata = 8'h0F; bus_wr = 1'b1;
        bit_addr = 8'hE7; bit_wval = 1'b1; bit_we = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bit_we = 1'b0;
        m[8'hE0] = 8'h0F;
        rdc(8'hE0, "R10 bus beats bit same register");
        @(negedge clk);
        bus_addr = 8'hF0; bus_wdata = 8'h11; bus_wr = 1'b1;
        bit_addr = 8'hE7; bit_wval = 1'b1; bit_we = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bit_we = 1'b0;
        m[8'hF0] = 8'h11; m[8'hE0] = 8'h8F;
        rdc(8'hF0, "R10 bus write other register");
        rdc(8'hE0, "R10 bit write other register");

        finish_run();
    end

endmodule